// File: doc/BRIEF.md
# Calendar Time Counter with Alarm and Interrupt Status

This core keeps wall-clock time for a chip: a day count plus hours, minutes and seconds that advance on a one-pulse-per-second strobe. The strobe comes from an external prescaler. A second set of registers holds an alarm time. When the running time becomes equal to the alarm time, an alarm event is raised. A down-counting minute stopwatch and nine periodic strobes feed the same event collection.

All events land in one sticky status register. Software clears a bit by writing 1 to it. An enable register masks the status bits, and the result drives one level interrupt line. Software reaches the core through a plain write strobe, a word address and a 16-bit data bus. Read data is returned combinationally for the address presented.

Top module: `rtc_calendar_core`

## Requirements
- R1: Registers sit at these byte offsets: 0x00 time hour/minute, 0x04 time seconds, 0x08 alarm hour/minute, 0x0C alarm seconds, 0x10 control, 0x14 status, 0x18 enable, 0x1C stopwatch, 0x20 day count, 0x24 alarm day. Both hour/minute registers hold the hour in bits 15:8 and the minute in bits 7:0. After reset every register reads 0 and the interrupt is low.
- R2: On each second strobe while running, seconds go from 59 to 0 and carry into minutes. Minutes go from 59 to 0 and carry into hours. Hours go from 23 to 0 and carry into the day count.
- R3: The day count is 16 bits wide, or 9 bits when the narrow-day build option is set, and it wraps to 0 past its maximum.
- R4: Control bits 7:5 are stored and read back, and the other control bits read 0. Bit 7 is the run enable. While bit 7 is 0, the time and stopwatch counters hold their values despite second strobes.
- R5: A software write to a time or stopwatch register in the same cycle as a strobe that would change that register sets the written value, and the strobe's change to that register is lost.
- R6: Status bit 2 (alarm) is set one cycle after day, hour, minute and second first become equal to the alarm day, hour, minute and second.
- R7: Status bit 4 latches each second strobe. Status bits 7 through 15 latch periodic strobes 0 through 8 in that order (strobe k sets bit 7+k). Each bit latches whether or not its enable bit is set, and whether or not the core is running.
- R8: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged. A clear and a new event on the same bit in the same cycle leave the bit set. Status and enable bits 1, 3, 5 and 6 always read 0.
- R9: The interrupt output is high exactly when some status bit and its enable bit are both 1.
- R10: The 6-bit stopwatch decrements once each time the seconds roll over while running. When it steps from 0 to 63, it sets status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| tick_periodic | input | 9 | One-cycle periodic strobes, 2 Hz up to 512 Hz |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq | output | 1 | Level interrupt request |

## Verification
Every cycle, the assertions check the following:
- The interrupt is never high without both a pending status bit and an enable bit.
- A stopped core keeps its seconds.
- Seconds wrap at 59, and each second strobe latches status bit 4.
- The alarm bit rises only right after time equals alarm.
- The stopwatch wrap sets status bit 0.

Some behaviours only the bench scenarios can show: full carry chains up to the day wrap, write-versus-strobe priority, write-one-to-clear racing a new event, periodic bit placement, and the exact cycle in which the alarm fires.

// File: rtl/rtc_pkg.sv
// Shared register offsets and status bit positions for the calendar core.
package rtc_pkg;
    localparam logic [5:0] OFS_HRMIN  = 6'h00;
    localparam logic [5:0] OFS_SEC    = 6'h04;
    localparam logic [5:0] OFS_AHRMIN = 6'h08;
    localparam logic [5:0] OFS_ASEC   = 6'h0C;
    localparam logic [5:0] OFS_CTRL   = 6'h10;
    localparam logic [5:0] OFS_STAT   = 6'h14;
    localparam logic [5:0] OFS_IEN    = 6'h18;
    localparam logic [5:0] OFS_SWATCH = 6'h1C;
    localparam logic [5:0] OFS_DAY    = 6'h20;
    localparam logic [5:0] OFS_ADAY   = 6'h24;

    localparam int ST_SW  = 0;
    localparam int ST_ALM = 2;
    localparam int ST_1HZ = 4;
    localparam int ST_P0  = 7;
    localparam int N_PERIODIC = 9;
    localparam logic [15:0] STAT_MASK = 16'hFF95;

    typedef struct packed {
        logic [4:0] hr;
        logic [5:0] min;
        logic [5:0] sec;
    } hms_t;
endpackage

// File: rtl/rtc_time_counter.sv
// Day/hour/minute/second counter. Advances on tick while run is high;
// software writes override the tick result per field. Assumes tick is a
// single-cycle strobe.
module rtc_time_counter
    import rtc_pkg::*;
#(
    parameter int DAY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             wr_hm,
    input  logic             wr_sec,
    input  logic             wr_day,
    input  logic [15:0]      wdata,
    output hms_t             now,
    output logic [DAY_W-1:0] day,
    output logic             minute_tick
);
    localparam logic [DAY_W-1:0] DAY_ONE = DAY_W'(1);

    hms_t             nxt;
    logic [DAY_W-1:0] nday;

    // Carry from seconds into minutes on this strobe.
    assign minute_tick = run && tick && (now.sec >= 6'd59);

    // Next-state: tick increment first, then field writes win.
    always_comb begin
        nxt  = now;
        nday = day;
        if (run && tick) begin
            if (now.sec >= 6'd59) begin
                nxt.sec = '0;
                if (now.min >= 6'd59) begin
                    nxt.min = '0;
                    if (now.hr >= 5'd23) begin
                        nxt.hr = '0;
                        nday   = day + DAY_ONE;
                    end else begin
                        nxt.hr = now.hr + 5'd1;
                    end
                end else begin
                    nxt.min = now.min + 6'd1;
                end
            end else begin
                nxt.sec = now.sec + 6'd1;
            end
        end
        if (wr_sec) nxt.sec = wdata[5:0];
        if (wr_hm) begin
            nxt.hr  = wdata[12:8];
            nxt.min = wdata[5:0];
        end
        if (wr_day) nday = wdata[DAY_W-1:0];
    end

    // Time state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now <= '0;
            day <= '0;
        end else begin
            now <= nxt;
            day <= nday;
        end
    end
endmodule

// File: rtl/rtc_alarm_match.sv
// Alarm registers and comparator. Raises a one-cycle event when the running
// time becomes equal to the alarm time (edge of equality, so a held match
// does not refire after software clears the status).
module rtc_alarm_match
    import rtc_pkg::*;
#(
    parameter int DAY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ahm,
    input  logic             wr_asec,
    input  logic             wr_aday,
    input  logic [15:0]      wdata,
    input  hms_t             now,
    input  logic [DAY_W-1:0] day,
    output hms_t             alm,
    output logic [DAY_W-1:0] alm_day,
    output logic             time_eq,
    output logic             alarm_evt
);
    logic eq_q;

    assign time_eq   = (now == alm) && (day == alm_day);
    assign alarm_evt = time_eq && !eq_q;

    // Alarm register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm     <= '0;
            alm_day <= '0;
        end else begin
            if (wr_ahm) begin
                alm.hr  <= wdata[12:8];
                alm.min <= wdata[5:0];
            end
            if (wr_asec) alm.sec <= wdata[5:0];
            if (wr_aday) alm_day <= wdata[DAY_W-1:0];
        end
    end

    // Previous equality; reset high so the reset-time match does not fire.
    always_ff @(posedge clk) begin
        if (!rst_n) eq_q <= 1'b1;
        else        eq_q <= time_eq;
    end
endmodule

// File: rtl/rtc_irq_ctrl.sv
// Sticky write-one-to-clear status, enable mask and level interrupt.
// Assumes events are single-cycle pulses; unimplemented bits stay zero.
module rtc_irq_ctrl
    import rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] events,
    input  logic        wr_stat,
    input  logic        wr_ien,
    input  logic [15:0] wdata,
    output logic [15:0] status,
    output logic [15:0] ien,
    output logic        irq
);
    logic [15:0] clr;

    assign clr = wr_stat ? wdata : 16'h0000;
    assign irq = |(status & ien);

    // Status: clear written ones, then set new events (events win).
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= ((status & ~clr) | events) & STAT_MASK;
    end

    // Enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien <= '0;
        else if (wr_ien) ien <= wdata & STAT_MASK;
    end
endmodule

// File: rtl/rtc_calendar_core.sv
// Calendar time core top: register decode, readback, control, stopwatch
// and event collection. Assumes tick inputs are synchronous single-cycle
// strobes and that bus_addr is stable while read data is consumed.
module rtc_calendar_core
    import rtc_pkg::*;
#(
    parameter bit DAY_NARROW = 1'b0,
    parameter int SW_W       = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_1hz,
    input  logic [N_PERIODIC-1:0] tick_periodic,
    input  logic                  bus_wr,
    input  logic [5:0]            bus_addr,
    input  logic [15:0]           bus_wdata,
    output logic [15:0]           bus_rdata,
    output logic                  irq
);
    localparam int DAY_W = DAY_NARROW ? 9 : 16;
    localparam logic [SW_W-1:0] SW_ONE = SW_W'(1);

    logic             wr_hm, wr_sec, wr_ahm, wr_asec, wr_ctrl;
    logic             wr_stat, wr_ien, wr_sw, wr_day, wr_aday;
    logic [2:0]       ctrl_q;
    logic             ctrl_en;
    hms_t             now, alm;
    logic [DAY_W-1:0] day, alm_day;
    logic             minute_tick, time_eq, alarm_evt;
    logic [SW_W-1:0]  sw_q;
    logic             sw_wrap;
    logic [15:0]      events, status, ien;
    logic [5:0]       cur_sec;

    // Write strobe decode per register.
    always_comb begin
        wr_hm   = bus_wr && (bus_addr == OFS_HRMIN);
        wr_sec  = bus_wr && (bus_addr == OFS_SEC);
        wr_ahm  = bus_wr && (bus_addr == OFS_AHRMIN);
        wr_asec = bus_wr && (bus_addr == OFS_ASEC);
        wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
        wr_stat = bus_wr && (bus_addr == OFS_STAT);
        wr_ien  = bus_wr && (bus_addr == OFS_IEN);
        wr_sw   = bus_wr && (bus_addr == OFS_SWATCH);
        wr_day  = bus_wr && (bus_addr == OFS_DAY);
        wr_aday = bus_wr && (bus_addr == OFS_ADAY);
    end

    // Control bits 7:5 (bit 7 = run).
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= bus_wdata[7:5];
    end
    assign ctrl_en = ctrl_q[2];

    rtc_time_counter #(.DAY_W(DAY_W)) u_time (
        .clk(clk), .rst_n(rst_n), .run(ctrl_en), .tick(tick_1hz),
        .wr_hm(wr_hm), .wr_sec(wr_sec), .wr_day(wr_day), .wdata(bus_wdata),
        .now(now), .day(day), .minute_tick(minute_tick)
    );

    rtc_alarm_match #(.DAY_W(DAY_W)) u_alarm (
        .clk(clk), .rst_n(rst_n), .wr_ahm(wr_ahm), .wr_asec(wr_asec),
        .wr_aday(wr_aday), .wdata(bus_wdata), .now(now), .day(day),
        .alm(alm), .alm_day(alm_day), .time_eq(time_eq), .alarm_evt(alarm_evt)
    );

    // Stopwatch: counts down per minute carry; write wins over the carry.
    assign sw_wrap = minute_tick && (sw_q == '0) && !wr_sw;
    always_ff @(posedge clk) begin
        if (!rst_n)           sw_q <= '0;
        else if (wr_sw)       sw_q <= bus_wdata[SW_W-1:0];
        else if (minute_tick) sw_q <= sw_q - SW_ONE;
    end

    // Event vector: fixed sources plus the periodic strobes.
    always_comb begin
        events         = '0;
        events[ST_SW]  = sw_wrap;
        events[ST_ALM] = alarm_evt;
        events[ST_1HZ] = tick_1hz;
    end
    logic [15:0] per_events;
    generate
        for (genvar k = 0; k < 16; k++) begin : g_per
            if (k >= ST_P0 && k < ST_P0 + N_PERIODIC) begin : g_on
                assign per_events[k] = tick_periodic[k-ST_P0];
            end else begin : g_off
                assign per_events[k] = 1'b0;
            end
        end
    endgenerate

    rtc_irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n), .events(events | per_events),
        .wr_stat(wr_stat), .wr_ien(wr_ien), .wdata(bus_wdata),
        .status(status), .ien(ien), .irq(irq)
    );

    assign cur_sec = now.sec;

    // Combinational readback for the presented address.
    always_comb begin
        case (bus_addr)
            OFS_HRMIN:  bus_rdata = {3'b000, now.hr, 2'b00, now.min};
            OFS_SEC:    bus_rdata = {10'd0, now.sec};
            OFS_AHRMIN: bus_rdata = {3'b000, alm.hr, 2'b00, alm.min};
            OFS_ASEC:   bus_rdata = {10'd0, alm.sec};
            OFS_CTRL:   bus_rdata = {8'd0, ctrl_q, 5'd0};
            OFS_STAT:   bus_rdata = status;
            OFS_IEN:    bus_rdata = ien;
            OFS_SWATCH: bus_rdata = 16'(sw_q);
            OFS_DAY:    bus_rdata = 16'(day);
            OFS_ADAY:   bus_rdata = 16'(alm_day);
            default:    bus_rdata = 16'h0000;
        endcase
    end
endmodule

// File: rtl/rtc_core_checker.sv
// Temporal checks on the calendar core, bound to every instance.
module rtc_core_checker #(
    parameter int SW_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick_1hz,
    input logic            bus_wr,
    input logic            ctrl_en,
    input logic [5:0]      cur_sec,
    input logic            minute_tick,
    input logic [SW_W-1:0] sw,
    input logic [15:0]     status,
    input logic [15:0]     ien,
    input logic            time_eq,
    input logic            irq
);
    assert_irq_needs_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((|ien) && (|status)));

    assert_hold_when_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !bus_wr) |=> $stable(cur_sec));

    assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && tick_1hz && cur_sec == 6'd59 && !bus_wr) |=> (cur_sec == 6'd0));

    assert_alarm_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[2]) |-> $past(time_eq));

    assert_second_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && !bus_wr) |=> status[4]);

    assert_stopwatch_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (minute_tick && sw == '0 && !bus_wr) |=> (sw == '1 && status[0]));
endmodule

bind rtc_calendar_core rtc_core_checker #(.SW_W(SW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_wr(bus_wr),
    .ctrl_en(ctrl_en), .cur_sec(cur_sec), .minute_tick(minute_tick),
    .sw(sw_q), .status(status), .ien(ien), .time_eq(time_eq), .irq(irq)
);

// File: tb/tb_rtc_calendar_core.sv
module tb_rtc_calendar_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic [8:0]  tick_periodic = '0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] e_day;
    int e_hr, e_min, e_sec;

    always #5 clk = ~clk;

    rtc_calendar_core dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .tick_periodic(tick_periodic),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d, input bit with_tick = 0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_1hz = with_tick;
        @(negedge clk);
        bus_wr = 1'b0; tick_1hz = 1'b0;
    endtask

    task automatic rd(input string req, input logic [5:0] a, input logic [15:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_1hz = 1'b1;
            @(negedge clk); tick_1hz = 1'b0;
        end
    endtask

    // Reference time step from R2/R3 (16-bit day).
    function automatic void step_model();
        if (e_sec >= 59) begin
            e_sec = 0;
            if (e_min >= 59) begin
                e_min = 0;
                if (e_hr >= 23) begin e_hr = 0; e_day = e_day + 16'd1; end
                else e_hr++;
            end else e_min++;
        end else e_sec++;
    endfunction

    function automatic logic [15:0] hm_word(input int h, input int m);
        return {8'(h), 8'(m)};
    endfunction

    function automatic logic [15:0] per_map(input logic [8:0] m);
        return {m, 7'd0};
    endfunction

    task automatic set_time(input logic [15:0] d, input int h, input int m, input int s);
        wr(6'h20, d);
        wr(6'h00, hm_word(h, m));
        wr(6'h04, 16'(s));
        e_day = d; e_hr = h; e_min = m; e_sec = s;
    endtask

    task automatic read_time(input string req);
        rd(req, 6'h20, e_day);
        rd(req, 6'h00, hm_word(e_hr, e_min));
        rd(req, 6'h04, 16'(e_sec));
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd("R1 ctrl", 6'h10, 16'h0000);
        rd("R1 status", 6'h14, 16'h0000);
        rd("R1 hrmin", 6'h00, 16'h0000);
        chk("R1 irq", 16'(irq), 16'h0000);

        // R4: control readback, unused bits zero
        wr(6'h10, 16'hFFFF);
        rd("R4 ctrl all ones", 6'h10, 16'h00E0);
        wr(6'h10, 16'h0080);
        rd("R4 ctrl run", 6'h10, 16'h0080);

        // R1: alarm hour/minute packing
        wr(6'h08, hm_word(17, 42));
        rd("R1 alarm hrmin", 6'h08, 16'h112A);

        // R3: day wrap from full carry chain
        set_time(16'hFFFF, 23, 59, 59);
        tick(1); step_model();
        read_time("R3 day wrap");
        chk("R3 day is zero", e_day, 16'h0000);

        // R2/R3: randomized carry chains
        for (int i = 0; i < 30; i++) begin
            int n;
            set_time(($urandom % 2) ? 16'hFFFF : 16'($urandom),
                     ($urandom % 2) ? 23 : int'($urandom % 24),
                     ($urandom % 2) ? 59 : int'($urandom % 60),
                     50 + int'($urandom % 10));
            n = 1 + int'($urandom % 12);
            tick(n);
            for (int j = 0; j < n; j++) step_model();
            read_time("R2 random rollover");
        end

        // R4: stopped core holds time; R7: second bit still latches
        set_time(16'd3, 4, 5, 6);
        wr(6'h14, 16'hFFFF);
        wr(6'h10, 16'h0000);
        tick(3);
        read_time("R4 hold when stopped");
        rd("R7 second latch while stopped", 6'h14, 16'h0010);
        wr(6'h10, 16'h0080);

        // R5: write wins over strobe
        set_time(16'd1, 1, 10, 59);
        wr(6'h00, 16'h0305, 1);
        rd("R5 hrmin write wins", 6'h00, 16'h0305);
        rd("R5 sec still steps", 6'h04, 16'h0000);
        wr(6'h04, 16'd30, 1);
        rd("R5 sec write wins", 6'h04, 16'd30);

        // R6: alarm
        set_time(16'd5, 10, 20, 58);
        wr(6'h24, 16'd5);
        wr(6'h08, hm_word(10, 21));
        wr(6'h0C, 16'd0);
        wr(6'h14, 16'hFFFF);
        tick(1);
        @(negedge clk);
        rd("R6 no alarm before match", 6'h14, 16'h0010);
        tick(1);
        rd("R6 alarm not yet latched", 6'h14, 16'h0010);
        @(negedge clk);
        rd("R6 alarm latched", 6'h14, 16'h0014);

        // R9: interrupt masking
        wr(6'h18, 16'h0004);
        chk("R9 irq enabled", 16'(irq), 16'h0001);
        wr(6'h18, 16'h0008);
        chk("R9 irq masked", 16'(irq), 16'h0000);
        wr(6'h18, 16'hFFFF);
        rd("R8 enable unused bits", 6'h18, 16'hFF95);
        wr(6'h18, 16'h0000);

        // R8: write-one-to-clear
        wr(6'h14, 16'h0000);
        rd("R8 write zero keeps", 6'h14, 16'h0014);
        wr(6'h14, 16'h0004);
        rd("R8 clear alarm bit", 6'h14, 16'h0010);
        wr(6'h14, 16'h0010, 1);
        rd("R8 clear races event", 6'h14, 16'h0010);
        wr(6'h14, 16'hFFFF);
        rd("R8 clear all", 6'h14, 16'h0000);

        // R7: periodic strobes, random masks
        for (int i = 0; i < 12; i++) begin
            logic [8:0] m;
            m = (i == 0) ? 9'h001 : (i == 1) ? 9'h100 : 9'($urandom);
            wr(6'h14, 16'hFFFF);
            @(negedge clk); tick_periodic = m;
            @(negedge clk); tick_periodic = '0;
            rd("R7 periodic map", 6'h14, per_map(m));
        end
        wr(6'h14, 16'hFFFF);

        // R10: stopwatch
        wr(6'h1C, 16'd1);
        set_time(16'd0, 0, 0, 59);
        tick(1);
        rd("R10 stopwatch step", 6'h1C, 16'd0);
        wr(6'h14, 16'hFFFF);
        wr(6'h04, 16'd59);
        tick(1);
        rd("R10 stopwatch wrap", 6'h1C, 16'd63);
        bus_addr = 6'h14; #1;
        chk("R10 stopwatch status", bus_rdata & 16'h0001, 16'h0001);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule